// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block follows the low-power operating state of a small controller core. It reacts to a SLEEP strobe from the CPU, to a handful of mode-control bits, to gated interrupt requests, to a reset request and to an oscillator-ready indication. From these it tells the rest of the chip four things: which mode is in force, whether the CPU must be held, whether the high-speed system oscillator must run, and which low-speed clock ratio to use. It also marks the start of an exception.

The modes are active, subsleep (CPU held, peripherals running on the watch clock), subactive (CPU running on a divided watch clock), watch, and a warm-up mode in which the system oscillator is started and the block waits for it to settle. A SLEEP strobe taken in active or subactive picks the next mode from the control bits. The same strobe also captures the requested watch-clock ratio, and that ratio is the only one used until the next strobe. An enabled, unmasked interrupt ends subsleep or watch and enters subactive. A reset request from any mode starts the oscillator. The reset exception is then signalled once the oscillator is ready and the request has gone away.

Top module: `lpm_seq`

## Requirements
- R1: After reset the block reports active mode (mode code 0), CPU not held, system oscillator enabled, divide select 00 (divide by 8), and no exception or illegal flag.
- R2: In subsleep (code 1) and watch (code 3) the CPU is held and the system oscillator is off. In subactive (code 2) the CPU runs and the oscillator is off. SLEEP strobes are ignored while the CPU is held.
- R3: In subsleep or watch, an interrupt request is ignored if the global mask is 1 or that source's enable bit is 0. The mode stays the same and no exception starts.
- R4: In subsleep or watch, a request whose enable is 1 while the mask is 0 moves the block to subactive on the next clock and raises exception-start with cause 0 (interrupt).
- R5: A SLEEP strobe in active or subactive selects the next mode, checking these conditions in this order. First, standby=0 with low-speed=1 goes to subsleep. Second, standby=1 with timer=1 goes to watch. Third, direct=1 with low-speed=0 and medium-speed=0 goes from active to subactive, or from subactive to warm-up (code 4).
- R6: A SLEEP strobe in active or subactive with any other control combination leaves the mode unchanged and raises the illegal flag for exactly one cycle.
- R7: The divide select encodes 00=/8, 01=/4, 10=/2, 11=/1. It loads the requested value on each accepted SLEEP strobe, illegal ones included, and holds it at all other times.
- R8: A reset request in any mode enters warm-up with the oscillator on and the CPU held, and it takes priority over interrupts. Active is entered with exception-start and cause 1 (reset) only on the cycle after the oscillator is ready and the request is low.
- R9: Exception-start is a single-cycle pulse. Cause is 0 whenever exception-start is 0.
- R10: Warm-up entered from subactive by a SLEEP strobe waits while the oscillator is not ready. It then enters active with no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sleep_stb | input | 1 | One-cycle SLEEP execution strobe from the CPU |
| ctl_standby | input | 1 | Standby control bit |
| ctl_lowspd | input | 1 | Low-speed-on control bit |
| ctl_timer | input | 1 | Timer-mode control bit |
| ctl_medspd | input | 1 | Medium-speed-on control bit |
| ctl_direct | input | 1 | Direct-transfer control bit |
| div_req | input | 2 | Requested watch-clock divide code |
| irq_req | input | NIRQ | Interrupt requests, one per source |
| irq_en | input | NIRQ | Per-source interrupt enables |
| irq_mask | input | 1 | Global interrupt mask, 1 blocks all |
| rst_req | input | 1 | Reset request |
| osc_stable | input | 1 | System oscillator output has settled |
| mode | output | 3 | Current mode code (0 active, 1 subsleep, 2 subactive, 3 watch, 4 warm-up) |
| cpu_halt | output | 1 | Hold the CPU |
| osc_en | output | 1 | Enable the system oscillator |
| exc_start | output | 1 | One-cycle exception start |
| exc_cause | output | 1 | Exception cause: 0 interrupt, 1 reset |
| div_sel | output | 2 | Latched watch-clock divide code |
| illegal | output | 1 | One-cycle flag for a rejected SLEEP combination |

## Verification
The embedded properties check these on every cycle: the width of the exception pulse, that the divide select does not change without a SLEEP strobe, that subsleep and watch hold against vetoed interrupts, that warm-up waits for the oscillator, and that the illegal flag leaves the mode unchanged. Other behaviour is shown only by the bench scenarios. This includes the ordering among overlapping control combinations, the exact divide encoding carried across several strobes, reset winning over a simultaneous wake request, and the difference in exception signalling between a reset-driven warm-up and a SLEEP-driven one.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE    = 3'd0,
    ST_SUBSLEEP  = 3'd1,
    ST_SUBACTIVE = 3'd2,
    ST_WATCH     = 3'd3,
    ST_WARM_GO   = 3'd4,
    ST_WARM_RST  = 3'd5
  } lpm_state_e;

  typedef enum logic [1:0] {
    TGT_NONE     = 2'd0,
    TGT_SUBSLEEP = 2'd1,
    TGT_WATCH    = 2'd2,
    TGT_DIRECT   = 2'd3
  } sleep_tgt_e;

  localparam int unsigned MODE_W      = 3;
  localparam logic [MODE_W-1:0] MODE_WARMUP = 3'd4;
  localparam int unsigned DIV_W       = 2;
  localparam logic [DIV_W-1:0] DIV_RESET = 2'b00;

endpackage

// File: rtl/lpm_wake.sv
module lpm_wake #(
  parameter int unsigned NIRQ = 4
) (
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            irq_mask,
  output logic            wake
);

  logic [NIRQ-1:0] gated;

  for (genvar g = 0; g < NIRQ; g++) begin : g_gate
    assign gated[g] = irq_req[g] & irq_en[g];
  end

  assign wake = (|gated) & ~irq_mask;

endmodule

// File: rtl/lpm_decode.sv
module lpm_decode
  import lpm_pkg::*;
(
  input  logic       standby,
  input  logic       lowspd,
  input  logic       timer,
  input  logic       medspd,
  input  logic       direct,
  output sleep_tgt_e tgt
);

  always_comb begin
    if (!standby && lowspd) begin
      tgt = TGT_SUBSLEEP;
    end else if (standby && timer) begin
      tgt = TGT_WATCH;
    end else if (direct && !lowspd && !medspd) begin
      tgt = TGT_DIRECT;
    end else begin
      tgt = TGT_NONE;
    end
  end

endmodule

// File: rtl/lpm_divlatch.sv
module lpm_divlatch
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] d,
  output logic [DIV_W-1:0] q
);

  logic [DIV_W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= DIV_RESET;
    else        q <= q_d;
  end

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R7

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int unsigned NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_stb,
  input  logic            ctl_standby,
  input  logic            ctl_lowspd,
  input  logic            ctl_timer,
  input  logic            ctl_medspd,
  input  logic            ctl_direct,
  input  logic [1:0]      div_req,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            irq_mask,
  input  logic            rst_req,
  input  logic            osc_stable,
  output logic [2:0]      mode,
  output logic            cpu_halt,
  output logic            osc_en,
  output logic            exc_start,
  output logic            exc_cause,
  output logic [1:0]      div_sel,
  output logic            illegal
);

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok = rst_sync[1];

  logic       wake;
  sleep_tgt_e tgt;

  lpm_wake #(.NIRQ(NIRQ)) u_wake (
    .irq_req (irq_req),
    .irq_en  (irq_en),
    .irq_mask(irq_mask),
    .wake    (wake)
  );

  lpm_decode u_decode (
    .standby(ctl_standby),
    .lowspd (ctl_lowspd),
    .timer  (ctl_timer),
    .medspd (ctl_medspd),
    .direct (ctl_direct),
    .tgt    (tgt)
  );

  lpm_state_e state_q, state_d;
  logic       exc_d, cause_d, ill_d;
  logic       cpu_runs;
  logic       div_load;

  assign cpu_runs = (state_q == ST_ACTIVE) || (state_q == ST_SUBACTIVE);
  assign div_load = sleep_stb && cpu_runs;

  lpm_divlatch u_div (
    .clk  (clk),
    .rst_n(rst_ok),
    .load (div_load),
    .d    (div_req),
    .q    (div_sel)
  );

  always_comb begin
    state_d = state_q;
    exc_d   = 1'b0;
    cause_d = 1'b0;
    ill_d   = 1'b0;
    unique case (state_q)
      ST_ACTIVE, ST_SUBACTIVE: begin
        if (rst_req) begin
          state_d = ST_WARM_RST;
        end else if (sleep_stb) begin
          unique case (tgt)
            TGT_SUBSLEEP: state_d = ST_SUBSLEEP;
            TGT_WATCH:    state_d = ST_WATCH;
            TGT_DIRECT:   state_d = (state_q == ST_ACTIVE) ? ST_SUBACTIVE : ST_WARM_GO;
            default:      ill_d   = 1'b1;
          endcase
        end
      end
      ST_SUBSLEEP, ST_WATCH: begin
        if (rst_req) begin
          state_d = ST_WARM_RST;
        end else if (wake) begin
          state_d = ST_SUBACTIVE;
          exc_d   = 1'b1;
        end
      end
      ST_WARM_GO: begin
        if (rst_req)         state_d = ST_WARM_RST;
        else if (osc_stable) state_d = ST_ACTIVE;
      end
      ST_WARM_RST: begin
        if (osc_stable && !rst_req) begin
          state_d = ST_ACTIVE;
          exc_d   = 1'b1;
          cause_d = 1'b1;
        end
      end
      default: state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      state_q   <= ST_ACTIVE;
      exc_start <= 1'b0;
      exc_cause <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      state_q   <= state_d;
      exc_start <= exc_d;
      exc_cause <= cause_d;
      illegal   <= ill_d;
    end
  end

  always_comb begin
    mode     = (state_q == ST_WARM_RST) ? MODE_WARMUP : 3'(state_q);
    cpu_halt = !cpu_runs;
    osc_en   = (state_q == ST_ACTIVE) || (state_q == ST_WARM_GO) || (state_q == ST_WARM_RST);
  end

  AST_EXC_SINGLE: assert property (@(posedge clk) disable iff (!rst_ok)
    exc_start |=> !exc_start); // R9
  AST_CAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_ok)
    !exc_start |-> !exc_cause); // R9
  AST_VETO_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    ((state_q == ST_SUBSLEEP || state_q == ST_WATCH) && !rst_req &&
     (irq_mask || ((irq_req & irq_en) == '0))) |=> (state_q == $past(state_q) && !exc_start)); // R3
  AST_WAKE_TARGET: assert property (@(posedge clk) disable iff (!rst_ok)
    (exc_start && !exc_cause) |-> state_q == ST_SUBACTIVE); // R4
  AST_ILLEGAL_KEEP: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(illegal) |-> state_q == $past(state_q)); // R6
  AST_WARM_WAIT: assert property (@(posedge clk) disable iff (!rst_ok)
    (state_q == ST_WARM_GO && !osc_stable && !rst_req) |=> state_q == ST_WARM_GO); // R10
  AST_RESET_OSC: assert property (@(posedge clk) disable iff (!rst_ok)
    rst_req |=> (osc_en && (cpu_halt || state_q == ST_ACTIVE))); // R8

endmodule

// File: tb/lpm_seq_bench.sv
module lpm_seq_bench;

  localparam int NIRQ = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_stb = 1'b0;
  logic ctl_standby = 1'b0, ctl_lowspd = 1'b0, ctl_timer = 1'b0;
  logic ctl_medspd = 1'b0, ctl_direct = 1'b0;
  logic [1:0] div_req = 2'b00;
  logic [NIRQ-1:0] irq_req = '0, irq_en = '0;
  logic irq_mask = 1'b0, rst_req = 1'b0, osc_stable = 1'b0;

  logic [2:0] mode;
  logic cpu_halt, osc_en, exc_start, exc_cause, illegal;
  logic [1:0] div_sel;

  always #10 clk = ~clk;

  lpm_seq #(.NIRQ(NIRQ)) u_lpm_seq (
    .clk(clk), .rst_n(rst_n), .sleep_stb(sleep_stb),
    .ctl_standby(ctl_standby), .ctl_lowspd(ctl_lowspd), .ctl_timer(ctl_timer),
    .ctl_medspd(ctl_medspd), .ctl_direct(ctl_direct), .div_req(div_req),
    .irq_req(irq_req), .irq_en(irq_en), .irq_mask(irq_mask),
    .rst_req(rst_req), .osc_stable(osc_stable),
    .mode(mode), .cpu_halt(cpu_halt), .osc_en(osc_en), .exc_start(exc_start),
    .exc_cause(exc_cause), .div_sel(div_sel), .illegal(illegal)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [9:0] exp_q[$];
  string      tag_q[$];

  function automatic logic [9:0] ev(input logic [2:0] m, input logic h, input logic o,
                                    input logic e, input logic c, input logic [1:0] d,
                                    input logic i);
    return {m, h, o, e, c, d, i};
  endfunction

  function automatic logic [9:0] observed();
    return {mode, cpu_halt, osc_en, exc_start, exc_cause, div_sel, illegal};
  endfunction

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b ({mode,halt,osc,exc,cause,div,ill})", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of inputs at the falling edge and queues the result due after the next rise
  task automatic step(input logic sl, input logic [4:0] ctl, input logic [1:0] dreq,
                      input logic [NIRQ-1:0] rq, input logic [NIRQ-1:0] en,
                      input logic im, input logic rr, input logic os,
                      input logic [9:0] exp, input string tag);
    @(negedge clk);
    sleep_stb = sl;
    {ctl_standby, ctl_lowspd, ctl_timer, ctl_medspd, ctl_direct} = ctl;
    div_req = dreq; irq_req = rq; irq_en = en;
    irq_mask = im; rst_req = rr; osc_stable = os;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // monitor: compares a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() != 0) begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, observed(), e);
      end
    end
  end

  localparam logic [2:0] A = 3'd0, SS = 3'd1, SA = 3'd2, W = 3'd3, WU = 3'd4;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", observed(), ev(A, 0, 1, 0, 0, 2'b00, 0));
    rst_n = 1'b1;
    step(0, 5'b00000, 2'b00, 4'h0, 4'h0, 0, 0, 0, ev(A, 0, 1, 0, 0, 2'b00, 0), "R1");
    step(0, 5'b00000, 2'b00, 4'h0, 4'h0, 0, 0, 0, ev(A, 0, 1, 0, 0, 2'b00, 0), "R1");
    step(0, 5'b00000, 2'b00, 4'h0, 4'h0, 0, 0, 0, ev(A, 0, 1, 0, 0, 2'b00, 0), "R1");
    // active -> subactive by direct transfer, ratio /2 captured
    step(1, 5'b00001, 2'b10, 4'h0, 4'h0, 0, 0, 0, ev(SA, 0, 0, 0, 0, 2'b10, 0), "R5");
    // R7 new request without SLEEP keeps old ratio
    step(0, 5'b00000, 2'b11, 4'h0, 4'h0, 0, 0, 0, ev(SA, 0, 0, 0, 0, 2'b10, 0), "R7");
    step(1, 5'b01000, 2'b11, 4'h0, 4'h0, 0, 0, 0, ev(SS, 1, 0, 0, 0, 2'b11, 0), "R2");
    // R3 vetoes: disabled source, then masked
    step(0, 5'b00000, 2'b00, 4'h1, 4'h0, 0, 0, 0, ev(SS, 1, 0, 0, 0, 2'b11, 0), "R3");
    step(0, 5'b00000, 2'b00, 4'h1, 4'h1, 1, 0, 0, ev(SS, 1, 0, 0, 0, 2'b11, 0), "R3");
    // R2 SLEEP ignored while halted
    step(1, 5'b10100, 2'b01, 4'h0, 4'h0, 0, 0, 0, ev(SS, 1, 0, 0, 0, 2'b11, 0), "R2");
    step(0, 5'b00000, 2'b00, 4'h1, 4'h1, 0, 0, 0, ev(SA, 0, 0, 1, 0, 2'b11, 0), "R4");
    step(0, 5'b00000, 2'b00, 4'h0, 4'h0, 0, 0, 0, ev(SA, 0, 0, 0, 0, 2'b11, 0), "R9");
    // R6 illegal combos; ratio still captured
    step(1, 5'b00000, 2'b01, 4'h0, 4'h0, 0, 0, 0, ev(SA, 0, 0, 0, 0, 2'b01, 1), "R6");
    step(0, 5'b00000, 2'b00, 4'h0, 4'h0, 0, 0, 0, ev(SA, 0, 0, 0, 0, 2'b01, 0), "R6");
    step(1, 5'b00011, 2'b01, 4'h0, 4'h0, 0, 0, 0, ev(SA, 0, 0, 0, 0, 2'b01, 1), "R6");
    // R5 watch outranks direct
    step(1, 5'b10101, 2'b00, 4'h0, 4'h0, 0, 0, 0, ev(W, 1, 0, 0, 0, 2'b00, 0), "R5");
    step(0, 5'b00000, 2'b00, 4'h4, 4'h4, 0, 0, 0, ev(SA, 0, 0, 1, 0, 2'b00, 0), "R4");
    step(0, 5'b00000, 2'b00, 4'h0, 4'h0, 0, 0, 0, ev(SA, 0, 0, 0, 0, 2'b00, 0), "R9");
    // R10 subactive -> warm-up -> active, no exception
    step(1, 5'b00001, 2'b00, 4'h0, 4'h0, 0, 0, 0, ev(WU, 1, 1, 0, 0, 2'b00, 0), "R10");
    step(0, 5'b00000, 2'b00, 4'h0, 4'h0, 0, 0, 0, ev(WU, 1, 1, 0, 0, 2'b00, 0), "R10");
    step(0, 5'b00000, 2'b00, 4'h0, 4'h0, 0, 0, 1, ev(A, 0, 1, 0, 0, 2'b00, 0), "R10");
    // R8 reset request from subsleep beats a wake request
    step(1, 5'b01000, 2'b10, 4'h0, 4'h0, 0, 0, 0, ev(SS, 1, 0, 0, 0, 2'b10, 0), "R2");
    step(0, 5'b00000, 2'b10, 4'h1, 4'h1, 0, 1, 0, ev(WU, 1, 1, 0, 0, 2'b10, 0), "R8");
    step(0, 5'b00000, 2'b10, 4'h0, 4'h0, 0, 1, 1, ev(WU, 1, 1, 0, 0, 2'b10, 0), "R8");
    step(0, 5'b00000, 2'b10, 4'h0, 4'h0, 0, 0, 1, ev(A, 0, 1, 1, 1, 2'b10, 0), "R8");
    step(0, 5'b00000, 2'b10, 4'h0, 4'h0, 0, 0, 1, ev(A, 0, 1, 0, 0, 2'b10, 0), "R9");
    step(0, 5'b00000, 2'b10, 4'h0, 4'h0, 0, 0, 1, ev(A, 0, 1, 0, 0, 2'b10, 0), "R9");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule